// File: doc/BRIEF.md
# Ring Transceiver Mode Control Register

This block is the mode register of a ring-network serial transceiver, together with the logic that turns its bits into control lines. Software reaches it through a plain write strobe, an address and a combinational read port. The one control word holds eight settings: the enable, the timing-master select, the active/bypass select, the two-frame synchronous delay select, the synchronous-boundary field, the asynchronous packet receive enable, the lock-ordering select and a wake-up trigger.

The bits drive several outputs. One picks the transmit clock source. One marks when the receive stream is passed straight to the transmit pin. Others are a one-cycle wake-up preamble request, the write strobe into the packet receive buffer, the frame-delay select and the lock-ordering select for the lock sequencer.

The mode decides which writes take effect. The boundary field only accepts writes while the node is timing master. The wake-up trigger only works in master mode. A request to clear the enable is held back until every synchronous DMA channel is idle, and it completes by itself once they are.

Top module: `ringModeCtrl`

## Requirements
- R1: After reset every stored bit is 0. The control word reads 0x0000, the bypass output is 1, and the local-clock select, the frame-delay output and the wake-up request are all 0.
- R2: The control word sits at address 0, with this layout: bit0 enable, bit1 active, bit2 master, bit3 sync delay, bit4 packet receive enable, bit5 lock ordering, bit6 wake-up trigger (always reads 0), bits 15:8 boundary field. Writes to any other address change nothing, and reads of any other address return 0.
- R3: The transmit-clock select output (1 = local synthesizer, 0 = recovered clock) follows the stored master bit.
- R4: The bypass output is 1 unless both enable and active are 1. The normal-transmit output is the inverse of the bypass output.
- R5: The two-frame delay output is 1 only when the sync-delay bit is 1 and the node is enabled and active. In either bypass case it is 0.
- R6: A write to the control word updates the boundary field only if the stored master bit, before the write, is 1. Otherwise the field keeps its old value.
- R7: The wake-up request is high for exactly the cycle of a control-word write that has bit6 = 1 while the stored master bit is 1. It is never high otherwise.
- R8: The packet-buffer write output equals the received-packet valid input ANDed with the stored packet receive enable.
- R9: A write that clears the enable while every DMA channel is idle clears it at that write's clock edge. A channel is idle when its enable, active and pending-enable inputs are all 0.
- R10: A write that clears the enable while any channel is not idle leaves the enable at 1. The disable is then held pending, and the enable clears at the end of the first cycle in which all channels are idle.
- R11: A control-word write with enable = 1 cancels a pending disable, even if the channels become idle in the same cycle. The enable then stays 1.
- R12: The lock-ordering output follows the stored lock-ordering bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr (combinational) |
| dmaChanEn | input | NUM_DMA | Per-channel synchronous DMA enable |
| dmaBusy | input | NUM_DMA | Per-channel DMA active status |
| dmaPendEn | input | NUM_DMA | Per-channel DMA pending-enable status |
| pktRxValid | input | 1 | A received asynchronous packet word is present |
| pktBufWr | output | 1 | Write strobe into the packet receive buffer |
| txClkLocal | output | 1 | 1 = transmit clock from local synthesizer, 0 = recovered clock |
| bypassRxToTx | output | 1 | Receive input routed directly to transmit output |
| txActive | output | 1 | Node transmits its own stream |
| frameDelay2 | output | 1 | Two-frame synchronous data delay selected |
| wakeReq | output | 1 | One-cycle wake-up preamble request |
| lockSel | output | 1 | Lock-ordering select to the lock sequencer |
| bndOut | output | BND_W | Current synchronous-boundary value |

## Verification
The collision that matters is a deferred disable completing in the same cycle that software writes the control word. The bench holds one DMA channel enabled and writes a cleared enable, so the disable goes pending. It then writes enable = 1 in exactly the cycle that releases the last DMA channel. The enable must stay 1 on every later cycle, which checks that the write takes priority over the completion of the pending disable. A second collision is a single write that clears the master bit and also changes the boundary. Here the stored master value decides, so the boundary change must land.

// File: rtl/ringModeCtrl_pkg.sv
package ringModeCtrl_pkg;
  localparam int BIT_EN   = 0;
  localparam int BIT_ACT  = 1;
  localparam int BIT_MST  = 2;
  localparam int BIT_SDLY = 3;
  localparam int BIT_PKT  = 4;
  localparam int BIT_LOCK = 5;
  localparam int BIT_WAKE = 6;

  typedef struct packed {
    logic wrCtrl;  // load plain mode bits
    logic wrBnd;   // load boundary field
    logic setEn;   // set enable
    logic clrEn;   // clear enable
    logic wake;    // wake-up preamble request
  } ctrlStrobe_t;
endpackage

// File: rtl/ringModeCtrlDecode.sv
module ringModeCtrlDecode
  import ringModeCtrl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int NUM_DMA   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wantEn,
  input  logic               wakeBit,
  input  logic               curEn,
  input  logic               curMst,
  input  logic [NUM_DMA-1:0] dmaChanEn,
  input  logic [NUM_DMA-1:0] dmaBusy,
  input  logic [NUM_DMA-1:0] dmaPendEn,
  output ctrlStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic [NUM_DMA-1:0] chanIdle;
  logic dmaIdle;
  logic hit;
  logic pending;

  for (genvar i = 0; i < NUM_DMA; i++) begin : g_idle
    assign chanIdle[i] = ~dmaChanEn[i] & ~dmaBusy[i] & ~dmaPendEn[i];
  end
  assign dmaIdle = &chanIdle;

  assign hit = wrEn && (addr == CTRL_A);

  always_comb begin
    strb        = '0;
    strb.wrCtrl = hit;
    strb.wrBnd  = hit && curMst;
    strb.setEn  = hit && wantEn;
    strb.clrEn  = dmaIdle && ((hit && !wantEn) || (pending && !hit));
    strb.wake   = hit && wakeBit && curMst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (hit) begin
      pending <= !wantEn && curEn && !dmaIdle;
    end else if (pending && dmaIdle) begin
      pending <= 1'b0;
    end
  end

  AST_EN_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (curEn && !dmaIdle) |=> curEn);                          // R10
  AST_PEND_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (pending && dmaIdle && !hit) |=> !curEn);                // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (hit && wantEn) |=> curEn);                              // R11
endmodule

// File: rtl/ringModeCtrlRegs.sv
module ringModeCtrlRegs
  import ringModeCtrl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CTRL_ADDR = 0,
  parameter int BND_W     = 8,
  parameter int BND_LSB   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pktRxValid,
  output logic [DATA_W-1:0] rdData,
  output logic              curEn,
  output logic              curMst,
  output logic              txClkLocal,
  output logic              bypassRxToTx,
  output logic              txActive,
  output logic              frameDelay2,
  output logic              pktBufWr,
  output logic              lockSel,
  output logic [BND_W-1:0]  bndOut
);
  localparam int BND_MSB = BND_LSB + BND_W - 1;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic enQ, actQ, mstQ, sdlyQ, pktQ, lockQ;
  logic [BND_W-1:0] bndQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      actQ  <= 1'b0;
      mstQ  <= 1'b0;
      sdlyQ <= 1'b0;
      pktQ  <= 1'b0;
      lockQ <= 1'b0;
      bndQ  <= '0;
    end else begin
      if (strb.setEn) enQ <= 1'b1;
      else if (strb.clrEn) enQ <= 1'b0;
      if (strb.wrCtrl) begin
        actQ  <= wrData[BIT_ACT];
        mstQ  <= wrData[BIT_MST];
        sdlyQ <= wrData[BIT_SDLY];
        pktQ  <= wrData[BIT_PKT];
        lockQ <= wrData[BIT_LOCK];
      end
      if (strb.wrBnd) bndQ <= wrData[BND_MSB:BND_LSB];
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == CTRL_A) begin
      rdData[BIT_EN]           = enQ;
      rdData[BIT_ACT]          = actQ;
      rdData[BIT_MST]          = mstQ;
      rdData[BIT_SDLY]         = sdlyQ;
      rdData[BIT_PKT]          = pktQ;
      rdData[BIT_LOCK]         = lockQ;
      rdData[BND_MSB:BND_LSB]  = bndQ;
    end
  end

  assign curEn        = enQ;
  assign curMst       = mstQ;
  assign txClkLocal   = mstQ;
  assign txActive     = enQ && actQ;
  assign bypassRxToTx = !(enQ && actQ);
  assign frameDelay2  = sdlyQ && enQ && actQ;
  assign pktBufWr     = pktRxValid && pktQ;
  assign lockSel      = lockQ;
  assign bndOut       = bndQ;

  AST_BND_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !mstQ |=> $stable(bndQ));                                // R6
  AST_WAKE_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    strb.wake |-> mstQ);                                     // R7
endmodule

// File: rtl/ringModeCtrl.sv
module ringModeCtrl
  import ringModeCtrl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CTRL_ADDR = 0,
  parameter int BND_W     = 8,
  parameter int BND_LSB   = 8,
  parameter int NUM_DMA   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_DMA-1:0] dmaChanEn,
  input  logic [NUM_DMA-1:0] dmaBusy,
  input  logic [NUM_DMA-1:0] dmaPendEn,
  input  logic               pktRxValid,
  output logic               pktBufWr,
  output logic               txClkLocal,
  output logic               bypassRxToTx,
  output logic               txActive,
  output logic               frameDelay2,
  output logic               wakeReq,
  output logic               lockSel,
  output logic [BND_W-1:0]   bndOut
);
  ctrlStrobe_t strb;
  logic curEn, curMst;

  ringModeCtrlDecode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .NUM_DMA(NUM_DMA)
  ) u_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wantEn(wrData[BIT_EN]), .wakeBit(wrData[BIT_WAKE]),
    .curEn(curEn), .curMst(curMst),
    .dmaChanEn(dmaChanEn), .dmaBusy(dmaBusy), .dmaPendEn(dmaPendEn),
    .strb(strb)
  );

  ringModeCtrlRegs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .BND_W(BND_W), .BND_LSB(BND_LSB)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .addr(addr),
    .pktRxValid(pktRxValid), .rdData(rdData), .curEn(curEn), .curMst(curMst),
    .txClkLocal(txClkLocal), .bypassRxToTx(bypassRxToTx), .txActive(txActive),
    .frameDelay2(frameDelay2), .pktBufWr(pktBufWr), .lockSel(lockSel),
    .bndOut(bndOut)
  );

  assign wakeReq = strb.wake;
endmodule

// File: tb/ringModeCtrl_tb.sv
`timescale 1ns/1ps
module ringModeCtrl_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int NUM_DMA = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [NUM_DMA-1:0] dmaChanEn = '0, dmaBusy = '0, dmaPendEn = '0;
  logic pktRxValid = 1'b0;
  logic pktBufWr, txClkLocal, bypassRxToTx, txActive, frameDelay2, wakeReq, lockSel;
  logic [7:0] bndOut;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  typedef enum int {S_RD, S_CLK, S_BYP, S_TXA, S_FD, S_WAKE, S_PKT, S_LOCK, S_BND} sel_e;
  typedef struct { string req; sel_e sel; logic [31:0] exp; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  ringModeCtrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dmaChanEn(dmaChanEn), .dmaBusy(dmaBusy),
    .dmaPendEn(dmaPendEn), .pktRxValid(pktRxValid), .pktBufWr(pktBufWr),
    .txClkLocal(txClkLocal), .bypassRxToTx(bypassRxToTx), .txActive(txActive),
    .frameDelay2(frameDelay2), .wakeReq(wakeReq), .lockSel(lockSel),
    .bndOut(bndOut)
  );

  function automatic logic [31:0] obs(sel_e s);
    case (s)
      S_RD:    return 32'(rdData);
      S_CLK:   return 32'(txClkLocal);
      S_BYP:   return 32'(bypassRxToTx);
      S_TXA:   return 32'(txActive);
      S_FD:    return 32'(frameDelay2);
      S_WAKE:  return 32'(wakeReq);
      S_PKT:   return 32'(pktBufWr);
      S_LOCK:  return 32'(lockSel);
      default: return 32'(bndOut);
    endcase
  endfunction

  // Monitor: compares queued expectations at the falling edge
  item_t it;
  always @(negedge clk) begin
    while (q.size() > 0) begin
      it = q.pop_front();
      nRun++;
      if (obs(it.sel) !== it.exp) begin
        nFail++;
        $display("FAIL %s sel=%s actual=0x%0h expected=0x%0h",
                 it.req, it.sel.name(), obs(it.sel), it.exp);
      end
    end
  end

  task automatic expect_(string req, sel_e sel, logic [31:0] exp);
    item_t x;
    x.req = req; x.sel = sel; x.exp = exp;
    q.push_back(x);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    step();
    wrEn = 1'b1; addr = a; wrData = d;
  endtask

  task automatic endWr();
    step();
    wrEn = 1'b0; addr = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    expect_("R1", S_RD, 32'h0);
    expect_("R1", S_BYP, 1);
    expect_("R1", S_CLK, 0);
    expect_("R1", S_FD, 0);
    expect_("R1", S_WAKE, 0);

    // R2 / R3: master bit
    wr(0, 16'h0004); endWr();
    expect_("R2", S_RD, 32'h0004);
    expect_("R3", S_CLK, 1);

    // R7 wake in master, full write
    wr(0, 16'hA57F);
    expect_("R7", S_WAKE, 1);
    endWr();
    expect_("R7", S_WAKE, 0);
    expect_("R2", S_RD, 32'hA53F);
    expect_("R12", S_LOCK, 1);
    expect_("R4", S_BYP, 0);
    expect_("R4", S_TXA, 1);
    expect_("R5", S_FD, 1);
    expect_("R6", S_BND, 32'hA5);
    pktRxValid = 1'b1;
    expect_("R8", S_PKT, 1);

    // R8 packet enable cleared
    wr(0, 16'hA52F); endWr();
    expect_("R8", S_PKT, 0);
    pktRxValid = 1'b0;

    // R4 / R5 enabled but not active
    wr(0, 16'hA52D); endWr();
    expect_("R4", S_BYP, 1);
    expect_("R4", S_TXA, 0);
    expect_("R5", S_FD, 0);

    // R2 other address
    wr(1, 16'hFFFF); endWr();
    expect_("R2", S_RD, 32'hA52D);
    step(); addr = 1;
    expect_("R2", S_RD, 32'h0);
    step(); addr = 0;

    // R6 leaving master in the same write still takes the boundary
    wr(0, 16'h5A29); endWr();
    expect_("R6", S_RD, 32'h5A29);
    expect_("R3", S_CLK, 0);
    // R6 slave write discards boundary
    wr(0, 16'h3329); endWr();
    expect_("R6", S_RD, 32'h5A29);
    // R7 wake in slave has no effect
    wr(0, 16'h5A69);
    expect_("R7", S_WAKE, 0);
    endWr();
    expect_("R7", S_RD, 32'h5A29);

    // R10 deferred disable
    dmaBusy[1] = 1'b1;
    wr(0, 16'h5A28); endWr();
    expect_("R10", S_RD, 32'h5A29);
    repeat (3) step();
    expect_("R10", S_RD, 32'h5A29);
    dmaBusy[1] = 1'b0;
    step();
    expect_("R10", S_RD, 32'h5A28);
    expect_("R10", S_BYP, 1);

    // R9 immediate disable when idle
    wr(0, 16'h5A29); endWr();
    expect_("R9", S_RD, 32'h5A29);
    wr(0, 16'h5A28); endWr();
    expect_("R9", S_RD, 32'h5A28);

    // R11 re-enable write in the cycle DMA goes idle
    wr(0, 16'h5A29); endWr();
    dmaPendEn[3] = 1'b1;
    wr(0, 16'h5A28); endWr();
    expect_("R11", S_RD, 32'h5A29);
    wr(0, 16'h5A2B);
    dmaPendEn[3] = 1'b0;
    endWr();
    step(); step();
    expect_("R11", S_RD, 32'h5A2B);
    expect_("R11", S_TXA, 1);

    step(); step();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule